// File: doc/BRIEF.md
# Calendar Counter with Start Gating

This block keeps wall-clock time as a set of BCD fields: seconds, minutes, hours (24-hour only), day of week, date, month and a two-digit year. A free-running sub-second counter sits in front of them. It is advanced by a single-cycle `subTick` pulse that comes from an external crystal divider. Each time the sub-second counter wraps, the seconds field steps and the carry ripples upward. A date carry follows the month length, including the February leap-year case.

Firmware loads any field through a write strobe that carries an address and a byte. Reset models a total loss of power. After reset, a failure flag reads 1 and the sub-second counter keeps counting. Seconds and all higher fields stay frozen until firmware has written at least one time field. From that write on, the counter runs until the next reset. The failure flag is cleared only by an explicit write.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the outputs read sec 00, min 00, hour 00, date 01, month 01, year 00, day of week 0, sub-second 0, and `failFlag` reads 1.
- R2: `subSec` counts `subTick` pulses from 0 to SUB_DIV-1 and then wraps to 0. It counts whether or not the clock has been started.
- R3: After reset the seven time fields do not change until the first write to a time address (0 to 6). A write to the failure address 0xB does not start them. Once started, they stay started until reset.
- R4: When started, every wrap of `subSec` advances sec through BCD 00 to 59. A seconds wrap advances min through 00 to 59. A minutes wrap advances hour through 00 to 23, with no 12-hour mode.
- R5: An hour wrap from 23 to 00 advances the date and the day of week together. The day of week counts 0 to 6 and wraps to 0 independently of the date.
- R6: The date wraps to 01 after the last day of its month. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the binary value of the BCD year is divisible by 4 (00 included) and 28 days otherwise. All other months have 31 days.
- R7: A date wrap in month 12 sets month to 01 and steps the year. Year 99 steps to 00.
- R8: A write with `wrAddr` 0 sec, 1 min, 2 hour, 3 date, 4 month, 5 year or 6 day of week loads `wrData` into that field by the next cycle. The write also clears `subSec` to 0. The write wins over a `subTick` in the same cycle, so no carry happens in that cycle. Writes to addresses 7 to 10 and 12 to 15 change no output.
- R9: A write to address 0xB with `wrData` bit 0 = 0 clears `failFlag`. With bit 0 = 1 the flag is left unchanged. Such a write does not touch `subSec` or the time fields. Only reset sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, models total power loss |
| subTick | input | 1 | One-cycle pulse per sub-second step |
| wrEn | input | 1 | Field write strobe |
| wrAddr | input | 4 | Field address |
| wrData | input | 8 | Write byte (BCD for time fields) |
| subSec | output | $clog2(SUB_DIV) | Sub-second count, binary |
| sec | output | 8 | Seconds, BCD |
| min | output | 8 | Minutes, BCD |
| hour | output | 8 | Hours 00-23, BCD |
| dow | output | 8 | Day of week 0-6 |
| date | output | 8 | Day of month, BCD |
| month | output | 8 | Month 01-12, BCD |
| year | output | 8 | Year 00-99, BCD |
| failFlag | output | 1 | Set at reset, cleared by firmware |

## Verification
The range assertions on hour and day of week assume that firmware writes only valid BCD that is in range for each field, and a date that exists in the loaded month. The bench loads only such values. Each field is set to just before a boundary and then one second of ticks is applied, so every carry starts from a legal state. Writes that coincide with a tick are made only in the cycle where the sub-second counter would wrap, which is the one case where write priority matters.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int FIELD_W    = 8;
  localparam int ADDR_W     = 4;
  localparam int NUM_FIELDS = 7;
  localparam int CASCADE    = 6;   // sec..year form the carry chain
  localparam logic [ADDR_W-1:0] FAIL_ADDR = 4'hB;
  localparam int FAIL_BIT = 0;

  // field index doubles as write address
  localparam int F_SEC   = 0;
  localparam int F_MIN   = 1;
  localparam int F_HOUR  = 2;
  localparam int F_DATE  = 3;
  localparam int F_MONTH = 4;
  localparam int F_YEAR  = 5;
  localparam int F_DOW   = 6;

  typedef struct packed {
    logic                  secTick;
    logic [NUM_FIELDS-1:0] load;
    logic [FIELD_W-1:0]    data;
  } calStrobe_t;

  function automatic logic [FIELD_W-1:0] bcdInc(input logic [FIELD_W-1:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [FIELD_W-1:0] daysInMonth(input logic [FIELD_W-1:0] m,
                                                     input logic [FIELD_W-1:0] y);
    logic [6:0] yBin;
    yBin = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
    case (m)
      8'h02:                      return (yBin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [FIELD_W-1:0] fieldFloor(input int idx);
    return (idx == F_DATE || idx == F_MONTH) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int SUB_DIV = 100,
  localparam int SUB_W  = (SUB_DIV > 1) ? $clog2(SUB_DIV) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              subTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [FIELD_W-1:0] wrData,
  output logic [SUB_W-1:0]  subCnt,
  output logic              failFlag,
  output calStrobe_t        strb
);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_DIV - 1);

  logic runEn;
  logic timeWr;
  logic subWrap;
  logic failClr;

  assign timeWr  = wrEn && (wrAddr < ADDR_W'(NUM_FIELDS));
  assign subWrap = subTick && (subCnt == SUB_LAST);
  assign failClr = wrEn && (wrAddr == FAIL_ADDR) && !wrData[FAIL_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subCnt   <= '0;
      runEn    <= 1'b0;
      failFlag <= 1'b1;
    end else begin
      if (timeWr)       subCnt <= '0;
      else if (subTick) subCnt <= subWrap ? '0 : subCnt + 1'b1;
      if (timeWr)       runEn <= 1'b1;
      if (failClr)      failFlag <= 1'b0;
    end
  end

  always_comb begin
    strb.secTick = subWrap && runEn && !timeWr;
    strb.data    = wrData;
    for (int i = 0; i < NUM_FIELDS; i++)
      strb.load[i] = wrEn && (wrAddr == ADDR_W'(i));
  end

  AST_SUB_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    subCnt <= SUB_LAST);  // R2
  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !(wrEn && wrAddr == FAIL_ADDR && !wrData[FAIL_BIT])) |=> failFlag);  // R9
  AST_FAIL_NO_SET: assert property (@(posedge clk) disable iff (!rstN)
    !failFlag |=> !failFlag);  // R9
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    runEn |=> runEn);  // R3
  AST_WRITE_SUB_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    timeWr |=> subCnt == '0);  // R8
endmodule

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  calStrobe_t         strb,
  output logic [FIELD_W-1:0] fld [NUM_FIELDS]
);
  logic [FIELD_W-1:0] limit [CASCADE];
  logic [CASCADE-1:0] atMax;
  logic [CASCADE:0]   carry;

  always_comb begin
    limit[F_SEC]   = 8'h59;
    limit[F_MIN]   = 8'h59;
    limit[F_HOUR]  = 8'h23;
    limit[F_DATE]  = daysInMonth(fld[F_MONTH], fld[F_YEAR]);
    limit[F_MONTH] = 8'h12;
    limit[F_YEAR]  = 8'h99;
  end

  assign carry[0] = strb.secTick;

  for (genvar i = 0; i < CASCADE; i++) begin : g_chain
    localparam logic [FIELD_W-1:0] FLOOR = fieldFloor(i);
    assign atMax[i]   = (fld[i] == limit[i]);
    assign carry[i+1] = carry[i] && atMax[i];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             fld[i] <= FLOOR;
      else if (strb.load[i]) fld[i] <= strb.data;
      else if (carry[i])     fld[i] <= atMax[i] ? FLOOR : bcdInc(fld[i]);
    end
  end

  // day of week steps on the same carry that steps the date
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 fld[F_DOW] <= '0;
    else if (strb.load[F_DOW]) fld[F_DOW] <= strb.data;
    else if (carry[F_DATE])    fld[F_DOW] <= (fld[F_DOW] == 8'd6) ? '0 : fld[F_DOW] + 1'b1;
  end

  AST_HOUR_24: assert property (@(posedge clk) disable iff (!rstN)
    fld[F_HOUR] <= 8'h23);  // R4
  AST_DOW_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    fld[F_DOW] <= 8'd6);  // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.secTick && strb.load == '0) |=>
      ($stable(fld[F_SEC]) && $stable(fld[F_MIN]) && $stable(fld[F_HOUR]) &&
       $stable(fld[F_DATE]) && $stable(fld[F_MONTH]) && $stable(fld[F_YEAR]) &&
       $stable(fld[F_DOW])));  // R3
  AST_YEAR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (fld[F_YEAR] != $past(fld[F_YEAR]) && !$past(strb.load[F_YEAR])) |->
      ($past(fld[F_MONTH]) == 8'h12 && fld[F_MONTH] == 8'h01));  // R7
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int SUB_DIV = 100,
  localparam int SUB_W  = (SUB_DIV > 1) ? $clog2(SUB_DIV) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               subTick,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [FIELD_W-1:0] wrData,
  output logic [SUB_W-1:0]   subSec,
  output logic [FIELD_W-1:0] sec,
  output logic [FIELD_W-1:0] min,
  output logic [FIELD_W-1:0] hour,
  output logic [FIELD_W-1:0] dow,
  output logic [FIELD_W-1:0] date,
  output logic [FIELD_W-1:0] month,
  output logic [FIELD_W-1:0] year,
  output logic               failFlag
);
  calStrobe_t         strb;
  logic [FIELD_W-1:0] fld [NUM_FIELDS];

  rtc_cal_ctrl #(.SUB_DIV(SUB_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .subTick(subTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .subCnt(subSec), .failFlag(failFlag), .strb(strb)
  );

  rtc_cal_datapath u_dp (.clk(clk), .rstN(rstN), .strb(strb), .fld(fld));

  assign sec   = fld[F_SEC];
  assign min   = fld[F_MIN];
  assign hour  = fld[F_HOUR];
  assign date  = fld[F_DATE];
  assign month = fld[F_MONTH];
  assign year  = fld[F_YEAR];
  assign dow   = fld[F_DOW];
endmodule

// File: tb/rtc_calendar_test.sv
`timescale 1ns/1ps
module rtc_calendar_test;
  localparam int SUB = 4;
  localparam int SW  = $clog2(SUB);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic subTick = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [SW-1:0] subSec;
  logic [7:0] sec, min, hour, dow, date, month, year;
  logic failFlag;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rtc_calendar #(.SUB_DIV(SUB)) uut (
    .clk(clk), .rstN(rstN), .subTick(subTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .subSec(subSec), .sec(sec), .min(min), .hour(hour),
    .dow(dow), .date(date), .month(month), .year(year), .failFlag(failFlag)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    subTick = 1'b1;
    repeat (n) @(negedge clk);
    subTick = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic testReset();
    check("R1 sec", sec, 8'h00);     check("R1 min", min, 8'h00);
    check("R1 hour", hour, 8'h00);   check("R1 date", date, 8'h01);
    check("R1 month", month, 8'h01); check("R1 year", year, 8'h00);
    check("R1 dow", dow, 8'h00);     check("R1 subSec", subSec, 0);
    check("R1 failFlag", failFlag, 1);
  endtask

  task automatic testPreStart();
    ticks(3);
    check("R2 subSec counts", subSec, 3);
    ticks(1);
    check("R2 subSec wraps", subSec, 0);
    check("R3 sec frozen", sec, 8'h00);
    wr(4'hB, 8'h01);
    ticks(SUB * 2);
    check("R3 fail write does not start", sec, 8'h00);
    check("R9 bit0=1 keeps flag", failFlag, 1);
    ticks(2);
    wr(4'hB, 8'h00);
    check("R9 flag cleared", failFlag, 0);
    check("R9 subSec untouched", subSec, 2);
    check("R3 still frozen", sec, 8'h00);
  endtask

  task automatic testStart();
    wr(4'd0, 8'h58);
    check("R8 sec loaded", sec, 8'h58);
    check("R8 subSec cleared", subSec, 0);
    ticks(SUB);
    check("R4 sec steps", sec, 8'h59);
    ticks(SUB);
    check("R4 sec wraps", sec, 8'h00);
    check("R4 min carry", min, 8'h01);
    check("R9 flag stays clear", failFlag, 0);
  endtask

  task automatic testHourWrap();
    wr(4'd2, 8'h23); wr(4'd1, 8'h59); wr(4'd0, 8'h59);
    wr(4'd6, 8'h06); wr(4'd4, 8'h03); wr(4'd3, 8'h15);
    ticks(SUB);
    check("R4 hour wraps", hour, 8'h00);
    check("R4 min wraps", min, 8'h00);
    check("R5 date steps", date, 8'h16);
    check("R5 dow wraps", dow, 8'h00);
  endtask

  task automatic dayEnd(input string tag, input logic [7:0] m, input logic [7:0] y,
                        input logic [7:0] d, input logic [7:0] expD,
                        input logic [7:0] expM, input logic [7:0] expY);
    wr(4'd5, y); wr(4'd4, m); wr(4'd3, d);
    wr(4'd2, 8'h23); wr(4'd1, 8'h59); wr(4'd0, 8'h59);
    ticks(SUB);
    check({tag, " date"}, date, expD);
    check({tag, " month"}, month, expM);
    check({tag, " year"}, year, expY);
  endtask

  task automatic testMonths();
    dayEnd("R6 feb28 y23", 8'h02, 8'h23, 8'h28, 8'h01, 8'h03, 8'h23);
    dayEnd("R6 feb28 y24", 8'h02, 8'h24, 8'h28, 8'h29, 8'h02, 8'h24);
    dayEnd("R6 feb28 y12", 8'h02, 8'h12, 8'h28, 8'h29, 8'h02, 8'h12);
    dayEnd("R6 feb29 y00", 8'h02, 8'h00, 8'h29, 8'h01, 8'h03, 8'h00);
    dayEnd("R6 apr30", 8'h04, 8'h10, 8'h30, 8'h01, 8'h05, 8'h10);
    dayEnd("R6 nov30", 8'h11, 8'h10, 8'h30, 8'h01, 8'h12, 8'h10);
    dayEnd("R6 jan30", 8'h01, 8'h10, 8'h30, 8'h31, 8'h01, 8'h10);
    dayEnd("R6 jan31", 8'h01, 8'h10, 8'h31, 8'h01, 8'h02, 8'h10);
    dayEnd("R7 dec31 y41", 8'h12, 8'h41, 8'h31, 8'h01, 8'h01, 8'h42);
    dayEnd("R7 dec31 y99", 8'h12, 8'h99, 8'h31, 8'h01, 8'h01, 8'h00);
  endtask

  task automatic testWritePriority();
    wr(4'd0, 8'h30);
    ticks(SUB - 1);
    check("R2 subSec at last", subSec, SUB - 1);
    subTick = 1'b1;
    wr(4'd0, 8'h10);
    subTick = 1'b0;
    check("R8 write wins sec", sec, 8'h10);
    check("R8 write wins subSec", subSec, 0);
    wr(4'd1, 8'h42);
    check("R8 min loaded", min, 8'h42);
    wr(4'd7, 8'h55); wr(4'hF, 8'h00);
    check("R8 unused addr sec", sec, 8'h10);
    check("R8 unused addr min", min, 8'h42);
    check("R8 unused addr subSec", subSec, 0);
  endtask

  task automatic testSecondReset();
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 flag set again", failFlag, 1);
    ticks(SUB * 2);
    check("R3 frozen after reset", sec, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPreStart();
    testStart();
    testHourWrap();
    testMonths();
    testWritePriority();
    testSecondReset();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule